// File: doc/BRIEF.md
# Serial Flash Page-Program Engine

This block is the target-side command logic of a serial flash device. It listens on a four-wire serial link in mode 0, with a chip select, a serial clock, data in and data out. It understands three commands: set the write-enable latch, read the status byte, and program a page. A program command carries a 24-bit address and any number of data bytes. The data bytes are collected in a page-sized staging buffer, and the write pointer wraps within the page. When chip select rises, the block checks the frame. If the frame is valid, it starts a self-timed program cycle. During that cycle the staged bytes are ANDed into a behavioural flash array, one byte per clock.

The link pins are treated as synchronous to the block clock. The serial clock must run well below the block clock, because both serial-clock edges are found by comparing each pin with its registered copy. Two bits are visible in the status byte: busy and write-enabled. Any command that would change state while busy is dropped. An asynchronous reset aborts a running cycle. After reset, chip select is ignored for a fixed recovery window. A per-page protection input blocks programming of selected pages. A peek port reads the array so its contents can be observed.

Top module: `flash_pp_engine`

## Requirements
- R1: Opcode 0x06 sets the write-enable flag (status bit 1), but only if chip select rises after exactly 8 bits and no cycle is running. If any extra bits follow the opcode, the flag does not change.
- R2: After opcode 0x05, the status byte {6'b0, write-enabled, busy} is shifted out on miso, MSB first. It is updated on falling edges of sck and repeats for as long as chip select stays low. It can be read during a program cycle.
- R3: Opcode 0x02 is followed by three address bytes, sent MSB first, and then data bytes. The data is staged starting at offset addr[7:0] of page addr[9:8]. Past offset 255 the write pointer wraps to offset 0 of the same page.
- R4: When more than 256 data bytes arrive, later bytes overwrite earlier ones. Only the last 256 bytes are programmed.
- R5: Page bytes that received no data in the frame keep their previous value.
- R6: Each programmed byte becomes the old array value ANDed with the new data, so bits can only go from 1 to 0.
- R7: A program cycle starts only if chip select rises on a byte boundary after at least one data byte. Any other program frame is dropped, and the write-enable flag stays as it was.
- R8: An accepted frame sets busy for exactly PROG_CYCLES clocks (at least PAGE_BYTES) after chip select rises. Busy and write-enabled both read 0 when the cycle ends.
- R9: A program frame is dropped when the write-enable flag is clear.
- R10: A program frame aimed at a page whose prot_map bit is 1 is dropped, and the write-enable flag stays set.
- R11: A program frame or write-enable frame that starts while busy is ignored. The running cycle keeps its timing and its data.
- R12: When rst_n goes low, busy and write-enabled are cleared, which aborts any cycle. After reset is released, a frame whose chip-select fall comes within RECOV_CYCLES clocks is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, synchronous to clk and much slower |
| mosi | input | 1 | Serial data into the block, sampled on sck rise |
| miso | output | 1 | Serial status data out, changes after sck fall |
| prot_map | input | NUM_PAGES | One protection bit per page |
| peek_addr | input | log2(NUM_PAGES*PAGE_BYTES) | Array read address |
| peek_data | output | 8 | Array byte at peek_addr |

## Verification
The bench builds the block with four pages of 256 bytes, PROG_CYCLES of 400 and RECOV_CYCLES of 50. With a serial bit time of 8 clocks, these values let one status read finish inside a cycle. A second program frame can then start while busy and run past the end of the cycle, which tests the rule that the frame is judged by the state when it began. The reset recovery window is short enough that a full write-enable frame can start inside it. The full 256-byte page keeps the wrap-around and last-256-bytes cases exact. A 300-byte frame still fits well within the run.

// File: rtl/fpp_pkg.sv
package fpp_pkg;
    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_PROG = 8'h02;
endpackage

// File: rtl/fpp_spi_front.sv
module fpp_spi_front (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       mosi,
    output logic       sck_fall,
    output logic       cs_fall,
    output logic       cs_rise,
    output logic       byte_done,
    output logic [7:0] byte_val,
    output logic [2:0] bit_pos
);
    typedef struct packed {
        logic       sck;
        logic       cs;
        logic [2:0] bits;
        logic [6:0] sh;
    } fr_t;

    fr_t fr_d, fr_q;
    logic sck_rise;

    always_comb begin
        fr_d      = fr_q;
        sck_rise  = sck & ~fr_q.sck;
        sck_fall  = ~sck & fr_q.sck;
        cs_fall   = ~cs_n & fr_q.cs;
        cs_rise   = cs_n & ~fr_q.cs;
        byte_val  = {fr_q.sh, mosi};
        byte_done = 1'b0;
        bit_pos   = fr_q.bits;
        fr_d.sck  = sck;
        fr_d.cs   = cs_n;
        if (fr_q.cs) begin
            fr_d.bits = '0;
        end else if (sck_rise) begin
            fr_d.sh   = {fr_q.sh[5:0], mosi};
            fr_d.bits = fr_q.bits + 3'd1;
            byte_done = (fr_q.bits == 3'd7);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q <= '{sck: 1'b0, cs: 1'b1, bits: 3'd0, sh: 7'd0};
        end else begin
            fr_q <= fr_d;
        end
    end
endmodule

// File: rtl/fpp_page_buf.sv
module fpp_page_buf #(
    parameter int PAGE_BYTES = 256,
    localparam int OFF_W = $clog2(PAGE_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             we,
    input  logic [OFF_W-1:0] woff,
    input  logic [7:0]       wdata,
    input  logic [OFF_W-1:0] roff,
    output logic [7:0]       rdata,
    output logic             rvalid
);
    logic [7:0]            store [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] filled;

    always_ff @(posedge clk) begin
        if (we) store[woff] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   filled <= '0;
        else if (clr) filled <= '0;
        else if (we)  filled[woff] <= 1'b1;
    end

    assign rdata  = store[roff];
    assign rvalid = filled[roff];
endmodule

// File: rtl/fpp_array.sv
module fpp_array #(
    parameter int NUM_PAGES  = 4,
    parameter int PAGE_BYTES = 256,
    localparam int DEPTH = NUM_PAGES * PAGE_BYTES,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] cells [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++) cells[i] = 8'hFF;
    end

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= cells[waddr] & wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/flash_pp_engine.sv
module flash_pp_engine
    import fpp_pkg::*;
#(
    parameter int NUM_PAGES    = 4,
    parameter int PAGE_BYTES   = 256,
    parameter int PROG_CYCLES  = 600,
    parameter int RECOV_CYCLES = 40
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          cs_n,
    input  logic                                          sck,
    input  logic                                          mosi,
    output logic                                          miso,
    input  logic [NUM_PAGES-1:0]                          prot_map,
    input  logic [$clog2(NUM_PAGES*PAGE_BYTES)-1:0]       peek_addr,
    output logic [7:0]                                    peek_data
);
    localparam int OFF_W    = $clog2(PAGE_BYTES);
    localparam int PG_W     = $clog2(NUM_PAGES);
    localparam int MEM_AW   = OFF_W + PG_W;
    localparam int PROG_LEN = (PROG_CYCLES > PAGE_BYTES) ? PROG_CYCLES : PAGE_BYTES;
    localparam int TMR_W    = $clog2(PROG_LEN + 1);
    localparam int REC_W    = $clog2(RECOV_CYCLES + 2);
    localparam logic [TMR_W-1:0] WALK_END = TMR_W'(PAGE_BYTES);
    localparam logic [TMR_W-1:0] LAST_TK  = TMR_W'(PROG_LEN - 1);
    localparam logic [REC_W-1:0] REC_INIT = REC_W'(RECOV_CYCLES);

    typedef struct packed {
        logic              frame_on;
        logic              busy_at_start;
        logic [2:0]        nbytes;
        logic [7:0]        opcode;
        logic [MEM_AW-1:0] addr;
        logic [OFF_W-1:0]  woff;
        logic              wel;
        logic              wip;
        logic [TMR_W-1:0]  timer;
        logic [REC_W-1:0]  recov;
        logic [7:0]        tx;
        logic [2:0]        txn;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             sck_fall, cs_fall, cs_rise, byte_done;
    logic [7:0]       byte_val;
    logic [2:0]       bit_pos;
    logic             buf_clr, buf_we, buf_rvalid, arr_we;
    logic [7:0]       buf_rdata, status;
    logic [PG_W-1:0]  page;
    logic             prog_path, idle_start;
    logic             st_wip, st_wel, st_frame, st_recov;

    fpp_spi_front u_front (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .sck_fall(sck_fall), .cs_fall(cs_fall), .cs_rise(cs_rise),
        .byte_done(byte_done), .byte_val(byte_val), .bit_pos(bit_pos)
    );

    fpp_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .we(buf_we),
        .woff(ctl_q.woff), .wdata(byte_val),
        .roff(ctl_q.timer[OFF_W-1:0]), .rdata(buf_rdata), .rvalid(buf_rvalid)
    );

    fpp_array #(.NUM_PAGES(NUM_PAGES), .PAGE_BYTES(PAGE_BYTES)) u_array (
        .clk(clk), .we(arr_we), .waddr({page, ctl_q.timer[OFF_W-1:0]}),
        .wdata(buf_rdata), .raddr(peek_addr), .rdata(peek_data)
    );

    always_comb begin
        ctl_d      = ctl_q;
        buf_clr    = 1'b0;
        buf_we     = 1'b0;
        arr_we     = 1'b0;
        status     = {6'b0, ctl_q.wel, ctl_q.wip};
        page       = ctl_q.addr[MEM_AW-1:OFF_W];
        idle_start = !ctl_q.busy_at_start && !ctl_q.wip;
        prog_path  = ctl_q.frame_on && (ctl_q.opcode == OP_PROG) && idle_start;

        if (ctl_q.recov != '0) ctl_d.recov = ctl_q.recov - 1'b1;

        // self-timed cycle: walk the staged page one byte per clock
        if (ctl_q.wip) begin
            arr_we      = (ctl_q.timer < WALK_END) && buf_rvalid;
            ctl_d.timer = ctl_q.timer + 1'b1;
            if (ctl_q.timer == LAST_TK) begin
                ctl_d.wip = 1'b0;
                ctl_d.wel = 1'b0;
            end
        end

        if (ctl_q.frame_on && byte_done) begin
            if (ctl_q.nbytes == 3'd0) begin
                ctl_d.opcode = byte_val;
                buf_clr = (byte_val == OP_PROG) && idle_start;
            end else if (ctl_q.nbytes < 3'd4) begin
                if (prog_path) begin
                    ctl_d.addr = MEM_AW'({ctl_q.addr, byte_val});
                    if (ctl_q.nbytes == 3'd3) ctl_d.woff = byte_val[OFF_W-1:0];
                end
            end else if (prog_path && ctl_q.wel) begin
                buf_we     = 1'b1;
                ctl_d.woff = ctl_q.woff + 1'b1;
            end
            if (ctl_q.nbytes < 3'd5) ctl_d.nbytes = ctl_q.nbytes + 3'd1;
        end

        // status shifter: load on the first fall of each byte, then shift
        if (ctl_q.frame_on && sck_fall && ctl_q.opcode == OP_RDSR && ctl_q.nbytes != 3'd0) begin
            ctl_d.tx  = (ctl_q.txn == 3'd0) ? status : {ctl_q.tx[6:0], 1'b0};
            ctl_d.txn = ctl_q.txn + 3'd1;
        end

        if (cs_fall && ctl_q.recov == '0) begin
            ctl_d.frame_on      = 1'b1;
            ctl_d.busy_at_start = ctl_q.wip;
            ctl_d.nbytes        = 3'd0;
            ctl_d.opcode        = 8'd0;
            ctl_d.tx            = 8'd0;
            ctl_d.txn           = 3'd0;
        end

        if (cs_rise) begin
            ctl_d.frame_on = 1'b0;
            if (ctl_q.frame_on && bit_pos == 3'd0 && idle_start) begin
                if (ctl_q.opcode == OP_WREN && ctl_q.nbytes == 3'd1) ctl_d.wel = 1'b1;
                if (prog_path && ctl_q.wel && ctl_q.nbytes == 3'd5 && !prot_map[page]) begin
                    ctl_d.wip   = 1'b1;
                    ctl_d.timer = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.recov <= REC_INIT;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign miso     = ctl_q.frame_on && (ctl_q.opcode == OP_RDSR) && ctl_q.tx[7];
    assign st_wip   = ctl_q.wip;
    assign st_wel   = ctl_q.wel;
    assign st_frame = ctl_q.frame_on;
    assign st_recov = (ctl_q.recov != '0);
endmodule

// File: rtl/fpp_chk.sv
module fpp_chk #(
    parameter int PROG_LEN = 600
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic wip,
    input logic wel,
    input logic arr_we,
    input logic frame_on,
    input logic recov_busy
);
    logic [31:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   busy_cnt <= '0;
        else if (wip) busy_cnt <= busy_cnt + 32'd1;
        else          busy_cnt <= '0;
    end

    p_busy_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> busy_cnt == 32'(PROG_LEN));

    p_end_clears_wel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> !wel);

    p_write_only_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> wip);

    p_wel_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wip |-> wel);

    p_start_on_cs_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> ($past(cs_n) && !$past(cs_n, 2)));

    p_recovery_deaf_r12: assert property (@(posedge clk) disable iff (!rst_n)
        recov_busy |-> !frame_on);
endmodule

bind flash_pp_engine fpp_chk #(.PROG_LEN(PROG_LEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wip(st_wip), .wel(st_wel),
    .arr_we(arr_we), .frame_on(st_frame), .recov_busy(st_recov)
);

// File: tb/test_flash_pp_engine.sv
`timescale 1ns/1ps
module test_flash_pp_engine;
    localparam int NP   = 4;
    localparam int PB   = 256;
    localparam int PROG = 400;
    localparam int REC  = 50;
    localparam int AW   = $clog2(NP * PB);
    localparam int HALF = 4;

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic miso;
    logic [NP-1:0] prot_map = '0;
    logic [AW-1:0] peek_addr = '0;
    logic [7:0]    peek_data;

    int checks = 0, errors = 0;
    logic [7:0] ref_mem [NP*PB];
    bit cap_on = 1'b0;

    typedef struct { logic [7:0] v; string req; } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    flash_pp_engine #(.NUM_PAGES(NP), .PAGE_BYTES(PB), .PROG_CYCLES(PROG),
                      .RECOV_CYCLES(REC)) i_flash_pp_engine (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso),
        .prot_map(prot_map), .peek_addr(peek_addr), .peek_data(peek_data)
    );

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xbit(bit b);
        mosi = b; tick(HALF); sck = 1'b1; tick(HALF); sck = 1'b0;
    endtask

    task automatic xbyte(logic [7:0] v);
        for (int i = 7; i >= 0; i--) xbit(v[i]);
    endtask

    task automatic cs_lo();
        tick(1); cs_n = 1'b0; tick(HALF);
    endtask

    task automatic cs_hi();
        tick(HALF); cs_n = 1'b1; tick(2 * HALF);
    endtask

    task automatic do_wren();
        cs_lo(); xbyte(8'h06); cs_hi();
    endtask

    // driver: push the expected status byte, the monitor compares it
    task automatic read_status(logic [7:0] exp, string req);
        cs_lo(); xbyte(8'h05);
        exp_q.push_back('{exp, req});
        cap_on = 1'b1; xbyte(8'h00); cap_on = 1'b0;
        cs_hi();
    endtask

    function automatic logic [7:0] pat(int seed, int k);
        return 8'((seed * 13 + k * 29) ^ (k >> 3));
    endfunction

    task automatic pp_frame(int pg, int off, int n, int extra, bit accept, int seed);
        logic [23:0] a;
        logic [7:0]  stage [PB];
        bit          hit   [PB];
        a = 24'(pg * PB + off);
        for (int i = 0; i < PB; i++) hit[i] = 1'b0;
        cs_lo(); xbyte(8'h02); xbyte(a[23:16]); xbyte(a[15:8]); xbyte(a[7:0]);
        for (int k = 0; k < n; k++) begin
            xbyte(pat(seed, k));
            stage[(off + k) % PB] = pat(seed, k);
            hit[(off + k) % PB]   = 1'b1;
        end
        for (int e = 0; e < extra; e++) xbit(1'b1);
        cs_hi();
        if (accept)
            for (int i = 0; i < PB; i++)
                if (hit[i]) ref_mem[pg * PB + i] = ref_mem[pg * PB + i] & stage[i];
    endtask

    task automatic chk_page(int pg, string req);
        int bad = -1;
        logic [7:0] got = 8'h00;
        logic [7:0] want = 8'h00;
        @(negedge clk);
        for (int i = 0; i < PB; i++) begin
            peek_addr = AW'(pg * PB + i);
            #1;
            if (peek_data !== ref_mem[pg * PB + i] && bad < 0) begin
                bad = i; got = peek_data; want = ref_mem[pg * PB + i];
            end
        end
        chk(bad < 0, req, {16'(bad), 8'h00, got}, {16'(bad), 8'h00, want});
    endtask

    // monitor: assemble status bytes at sck rise and compare with the queue
    initial begin
        int n;
        logic [7:0] sh;
        exp_t e;
        n = 0; sh = 8'h00;
        forever begin
            @(posedge sck);
            if (cap_on) begin
                sh = {sh[6:0], miso};
                n++;
                if (n == 8) begin
                    n = 0;
                    if (exp_q.size() == 0) chk(1'b0, "R2 empty-queue", {24'h0, sh}, 32'h0);
                    else begin
                        e = exp_q.pop_front();
                        chk(sh == e.v, e.req, {24'h0, sh}, {24'h0, e.v});
                    end
                end
            end else n = 0;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "R8 watchdog", 32'h0, 32'h1);
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < NP * PB; i++) ref_mem[i] = 8'hFF;
        tick(5);
        rst_n = 1'b1;
        tick(1);
        chk(miso == 1'b0, "R12 reset miso", {31'h0, miso}, 32'h0);
        chk_page(0, "R5 erased after reset");
        tick(REC + 10);
        read_status(8'h00, "R2 idle status");

        // R9: program without write enable
        pp_frame(0, 0, 2, 0, 1'b0, 1);
        read_status(8'h00, "R9 no cycle without WEL");
        chk_page(0, "R9 page untouched");

        // R1: write enable with trailing bits is dropped, clean one works
        cs_lo(); xbyte(8'h06); xbit(1'b0); xbit(1'b0); xbit(1'b0); cs_hi();
        read_status(8'h00, "R1 extra bits");
        do_wren();
        read_status(8'h02, "R1 WEL set");

        // R3 wrap, R8 timing, R2 read while busy
        pp_frame(1, 8'hFC, 6, 0, 1'b1, 3);
        read_status(8'h03, "R8 busy after cs rise");
        tick(PROG + 20);
        read_status(8'h00, "R8 cycle done");
        chk_page(1, "R3 R5 wrapped page");

        // R6: AND into already programmed bytes
        do_wren();
        pp_frame(1, 8'hFE, 4, 0, 1'b1, 7);
        tick(PROG + 150);
        chk_page(1, "R6 and program");

        // R4: 300 bytes, last 256 survive
        do_wren();
        pp_frame(2, 8'h80, 300, 0, 1'b1, 11);
        tick(PROG + 150);
        chk_page(2, "R4 last 256");

        // R7: misaligned end and no data
        do_wren();
        pp_frame(0, 5, 2, 3, 1'b0, 5);
        read_status(8'h02, "R7 partial byte");
        pp_frame(0, 5, 0, 0, 1'b0, 5);
        read_status(8'h02, "R7 no data");
        chk_page(0, "R7 page untouched");

        // R10: protected page
        prot_map = 4'b1000;
        pp_frame(3, 0, 4, 0, 1'b0, 9);
        read_status(8'h02, "R10 protected");
        chk_page(3, "R10 page untouched");
        prot_map = '0;

        // R11: program frame while busy
        pp_frame(0, 8'h10, 3, 0, 1'b1, 21);
        read_status(8'h03, "R11 busy");
        pp_frame(0, 8'h10, 3, 0, 1'b0, 0);
        read_status(8'h00, "R11 busy frame no cycle");
        chk_page(0, "R11 first data kept");

        // R11: write enable while busy
        do_wren();
        pp_frame(0, 8'h40, 1, 0, 1'b1, 33);
        do_wren();
        tick(PROG + 50);
        read_status(8'h00, "R11 wren while busy");
        chk_page(0, "R11 second program");

        // R12: reset aborts cycle and recovery window ignores a frame
        do_wren();
        pp_frame(3, 0, 1, 0, 1'b0, 2);
        tick(10);
        rst_n = 1'b0; tick(3); rst_n = 1'b1;
        cs_lo(); xbyte(8'h06); cs_hi();
        tick(REC);
        read_status(8'h00, "R12 abort and deaf window");
        do_wren();
        read_status(8'h02, "R12 live after recovery");

        tick(20);
        summary();
        $finish;
    end
endmodule